// File: doc/BRIEF.md
# Multibank DRAM Command Legality Checker

This block sits beside a DRAM controller and watches the command stream it emits. Each cycle carries one command code and a bank number. The checker keeps a model of every bank and of the device as a whole:

- which banks have a row open,
- how far each bank is through its activate delay or its precharge,
- the cross-bank windows left behind by the most recent activate, write and read commands,
- whether the device is in normal operation, power-down or self-refresh.

A command that breaks any rule raises a one-cycle violation flag with a 4-bit reason code. The flag appears in the cycle after the command is sampled. An illegal command is treated as if it had never been issued.

All timing values are static inputs counted in clock cycles (1 to 15):

- activate-to-column delay,
- activate-to-activate delay,
- write recovery,
- write-to-read delay,
- read-to-write delay,
- precharge time,
- write latency and read latency.

The burst length is also static: 4 or 8. Data pins, strobes, refresh scheduling and row addresses are not modelled. The end of the data burst is taken to be the latency plus half the burst length, counted from the column command.

Windows are counted from the command's issue cycle. A window of N cycles means that a command issued k cycles later is blocked while k < N.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset, all banks are closed with every timer expired, and the outputs read viol_o=0, reason_o=0. A read to any bank is then flagged with reason 8.
- R2: Commands are encoded as NOP=0, ACT=1, PRE=2, PREA=3, WR=4, WRA=5, RD=6, RDA=7, REF=8, SRE=9, SRX=10, PDE=11, PDX=12, MRS=13, EMRS=14, and 15 is reserved. The verdict on a command sampled at one clock edge appears after that edge and lasts one cycle. Legal commands give viol_o=0 with reason 0. NOP is always legal.
- R3: REF, SRE, PDE, MRS and EMRS are legal only when no bank is open and no bank is precharging; otherwise they are flagged with reason 3. PRE and PREA are flagged with reason 4 when no bank is open. A PRE to a closed bank while another bank is open is legal and has no effect.
- R4: The checks on ACT are applied in this priority order:
  - an ACT to an open bank gives reason 5;
  - an ACT to a bank that is still precharging gives reason 6;
  - an ACT sooner than tRRD after the last legal ACT to any bank gives reason 7.
- R5: A WR, WRA, RD or RDA to a closed bank gives reason 8. The same commands issued sooner than tRCD after that bank's ACT give reason 9.
- R6: A WR or WRA in the cycle right after a legal WR or WRA gives reason 10. An RD or RDA in the cycle right after a legal RD or RDA gives reason 11.
- R7: After a legal WR or WRA, an RD or RDA is flagged with reason 12 for a window of WL + BL/2 + tWTR cycles.
- R8: After a legal WRA, an RDA is flagged with reason 13 for a window of WL + BL/2 + tWR cycles. This check takes priority over reason 12.
- R9: After a legal RD or RDA, a WR or WRA is flagged with reason 14 for a window of tRTW cycles.
- R10: PRE and PREA close each open bank they address, and an ACT to that bank is then blocked for tRP cycles. WRA and RDA close their bank at issue. The ACT block then lasts WL + BL/2 + tWR + tRP cycles after a WRA, and RL + BL/2 + tRP cycles after an RDA.
- R11: PDE enters power-down and SRE enters self-refresh. In either state, only the matching exit command (PDX or SRX) and NOP are legal; anything else gives reason 1. PDX or SRX issued in normal operation gives reason 2.
- R12: An illegal command leaves unchanged:
  - the bank states,
  - the device mode,
  - every timer,
  - the same-direction gap tracking.
- R13: Code 15 gives reason 15 in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 4 | Command code |
| bank_i | input | BANK_W | Bank number of the command |
| t_rcd_i | input | TW | Activate-to-column delay, cycles |
| t_rrd_i | input | TW | Activate-to-activate delay, cycles |
| t_wr_i | input | TW | Write recovery, cycles |
| t_wtr_i | input | TW | Write-to-read delay, cycles |
| t_rtw_i | input | TW | Read-to-write delay, cycles |
| t_rp_i | input | TW | Precharge time, cycles |
| wl_i | input | TW | Write latency, cycles |
| rl_i | input | TW | Read latency, cycles |
| bl8_i | input | 1 | 1 selects burst length 8, 0 selects 4 |
| viol_o | output | 1 | One-cycle violation pulse |
| reason_o | output | 4 | Violation reason code, 0 when legal |

## Verification
The bench probes each window at its last blocked cycle and its first open cycle. A counter that is off by one therefore shows up as a wrong verdict on one side of the boundary.

- RDA and RD are issued one cycle apart after a WRA. A design that used one window for both would pass or reject them together.
- A same-direction column command follows an illegal one. A design that let the rejected command refresh the gap would flag the third command.
- An ACT is issued while the device is in power-down, and a column command follows the exit. A design that let the illegal ACT open the bank would not report the bank as closed.
- Burst length 8 is exercised so that a hard-wired half-burst of two is caught.

// File: rtl/dcg_pkg.sv
// Package: encodings shared by the command legality checker.
// Assumes a 4-bit command field and a 4-bit reason field.
package dcg_pkg;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_ACT  = 4'd1,
        C_PRE  = 4'd2,
        C_PREA = 4'd3,
        C_WR   = 4'd4,
        C_WRA  = 4'd5,
        C_RD   = 4'd6,
        C_RDA  = 4'd7,
        C_REF  = 4'd8,
        C_SRE  = 4'd9,
        C_SRX  = 4'd10,
        C_PDE  = 4'd11,
        C_PDX  = 4'd12,
        C_MRS  = 4'd13,
        C_EMRS = 4'd14,
        C_RSV  = 4'd15
    } cmd_e;

    typedef enum logic [3:0] {
        V_NONE    = 4'd0,
        V_LOWPWR  = 4'd1,
        V_BADEXIT = 4'd2,
        V_NOTIDLE = 4'd3,
        V_NOOPEN  = 4'd4,
        V_ROWOPEN = 4'd5,
        V_BANKPRE = 4'd6,
        V_RRD     = 4'd7,
        V_CLOSED  = 4'd8,
        V_RCD     = 4'd9,
        V_WRGAP   = 4'd10,
        V_RDGAP   = 4'd11,
        V_WTR     = 4'd12,
        V_RDAWRA  = 4'd13,
        V_RTW     = 4'd14,
        V_BADCODE = 4'd15
    } rsn_e;

    typedef enum logic [1:0] {
        M_NORM = 2'd0,
        M_PD   = 2'd1,
        M_SR   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        D_NONE = 2'd0,
        D_WR   = 2'd1,
        D_RD   = 2'd2
    } dir_e;

endpackage

// File: rtl/dcg_bank_slot.sv
// Module: state of one bank.
// Tracks whether a row is open, the remaining activate-to-column delay, and
// the remaining cycles before the bank may be activated again (precharge,
// including any auto-precharge action folded in).
// Assumes the caller raises at most one hit per cycle, and only for legal
// commands.
module dcg_bank_slot #(
    parameter int TW = 4,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_hit,
    input  logic          pre_hit,
    input  logic          auto_hit,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_rp,
    input  logic [CW-1:0] auto_len,
    output logic          open_o,
    output logic          rcd_busy_o,
    output logic          pre_busy_o
);
    logic          open_q;
    logic [TW-1:0] rcd_q;
    logic [CW-1:0] cls_q;
    logic [TW-1:0] rcd_load;
    logic [CW-1:0] rp_load;

    // Timer load values: parameter minus one, saturating at zero.
    always_comb begin
        rcd_load = (t_rcd == '0) ? '0 : t_rcd - 1'b1;
        rp_load  = (t_rp == '0) ? '0 : CW'(t_rp) - 1'b1;
    end

    // Update the open flag and the two bank timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            rcd_q  <= '0;
            cls_q  <= '0;
        end else begin
            rcd_q <= (rcd_q == '0) ? '0 : rcd_q - 1'b1;
            cls_q <= (cls_q == '0) ? '0 : cls_q - 1'b1;
            if (act_hit) begin
                open_q <= 1'b1;
                rcd_q  <= rcd_load;
            end else if (pre_hit && open_q) begin
                open_q <= 1'b0;
                cls_q  <= rp_load;
            end else if (auto_hit) begin
                open_q <= 1'b0;
                cls_q  <= auto_len;
            end
        end
    end

    assign open_o     = open_q;
    assign rcd_busy_o = (rcd_q != '0);
    assign pre_busy_o = (cls_q != '0);

    // R10
    open_after_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> ($past(cls_q) == '0));

endmodule

// File: rtl/dcg_bus_timers.sv
// Module: device-wide timers shared by all banks.
// Holds the activate spacing, the write-to-read and read-to-write windows,
// the auto-precharge write window, and the direction of the previous cycle's
// legal column command.
// Assumes the go strobes are raised only for legal commands.
module dcg_bus_timers
    import dcg_pkg::*;
#(
    parameter int TW = 4,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          wr_go,
    input  logic          wra_go,
    input  logic          rd_go,
    input  logic [TW-1:0] t_rrd,
    input  logic [TW-1:0] t_wtr,
    input  logic [TW-1:0] t_rtw,
    input  logic [TW-1:0] t_wr,
    input  logic [TW-1:0] wl,
    input  logic          bl8,
    output logic          rrd_busy,
    output logic          wtr_busy,
    output logic          wra_busy,
    output logic          rtw_busy,
    output dir_e          prev_dir
);
    logic [TW-1:0] rrd_q, rtw_q;
    logic [CW-1:0] wtr_q, wra_q;
    dir_e          prev_q;
    logic [CW-1:0] half, wtr_len, wra_len;

    // Window lengths minus one, measured from the column command.
    always_comb begin
        half    = bl8 ? CW'(4) : CW'(2);
        wtr_len = CW'(wl) + half + CW'(t_wtr) - 1'b1;
        wra_len = CW'(wl) + half + CW'(t_wr) - 1'b1;
    end

    // Load the timers on legal commands, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q  <= '0;
            rtw_q  <= '0;
            wtr_q  <= '0;
            wra_q  <= '0;
            prev_q <= D_NONE;
        end else begin
            if (act_go) rrd_q <= (t_rrd == '0) ? '0 : t_rrd - 1'b1;
            else        rrd_q <= (rrd_q == '0) ? '0 : rrd_q - 1'b1;
            if (rd_go)  rtw_q <= (t_rtw == '0) ? '0 : t_rtw - 1'b1;
            else        rtw_q <= (rtw_q == '0) ? '0 : rtw_q - 1'b1;
            if (wr_go)  wtr_q <= wtr_len;
            else        wtr_q <= (wtr_q == '0) ? '0 : wtr_q - 1'b1;
            if (wra_go) wra_q <= wra_len;
            else        wra_q <= (wra_q == '0) ? '0 : wra_q - 1'b1;
            prev_q <= wr_go ? D_WR : (rd_go ? D_RD : D_NONE);
        end
    end

    assign rrd_busy = (rrd_q != '0);
    assign rtw_busy = (rtw_q != '0);
    assign wtr_busy = (wtr_q != '0);
    assign wra_busy = (wra_q != '0);
    assign prev_dir = prev_q;

    // R7
    wtr_window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> wtr_busy);

    // R8
    wra_window_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wra_busy) |-> $past(wra_go));

endmodule

// File: rtl/dcg_rules.sv
// Module: combinational legality decision.
// Maps the current command, its bank, the device mode and the tracked
// timers to a reason code; V_NONE means the command is legal.
// Assumes all state inputs are registered elsewhere.
module dcg_rules
    import dcg_pkg::*;
#(
    parameter int NB     = 8,
    parameter int BANK_W = 3
) (
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  mode_e             mode,
    input  logic [NB-1:0]     open_vec,
    input  logic [NB-1:0]     rcd_vec,
    input  logic [NB-1:0]     pre_vec,
    input  logic              rrd_busy,
    input  logic              wtr_busy,
    input  logic              wra_busy,
    input  logic              rtw_busy,
    input  dir_e              prev_dir,
    output rsn_e              rsn
);
    logic sel_open, sel_rcd, sel_pre, any_open, all_quiet;

    // Status of the addressed bank and of the device as a whole.
    always_comb begin
        sel_open  = open_vec[bank];
        sel_rcd   = rcd_vec[bank];
        sel_pre   = pre_vec[bank];
        any_open  = |open_vec;
        all_quiet = !any_open && !(|pre_vec);
    end

    // Reason selection in priority order.
    always_comb begin
        rsn = V_NONE;
        if (cmd == C_RSV) begin
            rsn = V_BADCODE;
        end else if (mode != M_NORM) begin
            if (!(cmd == C_NOP ||
                  (mode == M_PD && cmd == C_PDX) ||
                  (mode == M_SR && cmd == C_SRX)))
                rsn = V_LOWPWR;
        end else begin
            case (cmd)
                C_PDX, C_SRX:
                    rsn = V_BADEXIT;
                C_REF, C_SRE, C_PDE, C_MRS, C_EMRS:
                    if (!all_quiet) rsn = V_NOTIDLE;
                C_PRE, C_PREA:
                    if (!any_open) rsn = V_NOOPEN;
                C_ACT: begin
                    if (sel_open)     rsn = V_ROWOPEN;
                    else if (sel_pre) rsn = V_BANKPRE;
                    else if (rrd_busy) rsn = V_RRD;
                end
                C_WR, C_WRA: begin
                    if (!sel_open)              rsn = V_CLOSED;
                    else if (sel_rcd)           rsn = V_RCD;
                    else if (prev_dir == D_WR)  rsn = V_WRGAP;
                    else if (rtw_busy)          rsn = V_RTW;
                end
                C_RD: begin
                    if (!sel_open)              rsn = V_CLOSED;
                    else if (sel_rcd)           rsn = V_RCD;
                    else if (prev_dir == D_RD)  rsn = V_RDGAP;
                    else if (wtr_busy)          rsn = V_WTR;
                end
                C_RDA: begin
                    if (!sel_open)              rsn = V_CLOSED;
                    else if (sel_rcd)           rsn = V_RCD;
                    else if (prev_dir == D_RD)  rsn = V_RDGAP;
                    else if (wra_busy)          rsn = V_RDAWRA;
                    else if (wtr_busy)          rsn = V_WTR;
                end
                default: rsn = V_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dram_cmd_guard.sv
// Module: top of the multibank DRAM command legality checker.
// Samples one command per clock, judges it against the tracked bank and
// device state, and reports the verdict registered one cycle later.
// Legal commands update the state; illegal commands are discarded.
// Assumes the timing inputs are static and within 1..15.
module dram_cmd_guard
    import dcg_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int TW     = 4,
    parameter int CW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [TW-1:0]     t_rcd_i,
    input  logic [TW-1:0]     t_rrd_i,
    input  logic [TW-1:0]     t_wr_i,
    input  logic [TW-1:0]     t_wtr_i,
    input  logic [TW-1:0]     t_rtw_i,
    input  logic [TW-1:0]     t_rp_i,
    input  logic [TW-1:0]     wl_i,
    input  logic [TW-1:0]     rl_i,
    input  logic              bl8_i,
    output logic              viol_o,
    output logic [3:0]        reason_o
);
    localparam int NB = 2 ** BANK_W;

    cmd_e          cmd;
    rsn_e          rsn;
    mode_e         mode_q;
    logic          legal;
    logic          act_go, wr_go, wra_go, rd_go, rda_go;
    logic [NB-1:0] open_vec, rcd_vec, pre_vec;
    logic          rrd_busy, wtr_busy, wra_busy, rtw_busy;
    dir_e          prev_dir;
    logic [CW-1:0] half, auto_len;
    logic          viol_q;
    rsn_e          rsn_q;

    // Decode the command and qualify the action strobes with legality.
    always_comb begin
        cmd    = cmd_e'(cmd_i);
        legal  = (rsn == V_NONE);
        act_go = legal && (cmd == C_ACT);
        wra_go = legal && (cmd == C_WRA);
        wr_go  = legal && (cmd == C_WR || cmd == C_WRA);
        rda_go = legal && (cmd == C_RDA);
        rd_go  = legal && (cmd == C_RD || cmd == C_RDA);
    end

    // Close-to-reopen span for auto-precharge, minus one.
    always_comb begin
        half = bl8_i ? CW'(4) : CW'(2);
        if (cmd == C_WRA)
            auto_len = CW'(wl_i) + half + CW'(t_wr_i) + CW'(t_rp_i) - 1'b1;
        else
            auto_len = CW'(rl_i) + half + CW'(t_rp_i) - 1'b1;
    end

    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        logic hit_here, act_hit, pre_hit, auto_hit;

        // Route legal commands to the bank they address.
        always_comb begin
            hit_here = (bank_i == BANK_W'(gi));
            act_hit  = act_go && hit_here;
            pre_hit  = legal && ((cmd == C_PRE && hit_here) || cmd == C_PREA);
            auto_hit = (wra_go || rda_go) && hit_here;
        end

        dcg_bank_slot #(.TW(TW), .CW(CW)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_hit    (act_hit),
            .pre_hit    (pre_hit),
            .auto_hit   (auto_hit),
            .t_rcd      (t_rcd_i),
            .t_rp       (t_rp_i),
            .auto_len   (auto_len),
            .open_o     (open_vec[gi]),
            .rcd_busy_o (rcd_vec[gi]),
            .pre_busy_o (pre_vec[gi])
        );
    end

    dcg_bus_timers #(.TW(TW), .CW(CW)) i_timers (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_go   (act_go),
        .wr_go    (wr_go),
        .wra_go   (wra_go),
        .rd_go    (rd_go),
        .t_rrd    (t_rrd_i),
        .t_wtr    (t_wtr_i),
        .t_rtw    (t_rtw_i),
        .t_wr     (t_wr_i),
        .wl       (wl_i),
        .bl8      (bl8_i),
        .rrd_busy (rrd_busy),
        .wtr_busy (wtr_busy),
        .wra_busy (wra_busy),
        .rtw_busy (rtw_busy),
        .prev_dir (prev_dir)
    );

    dcg_rules #(.NB(NB), .BANK_W(BANK_W)) i_rules (
        .cmd      (cmd),
        .bank     (bank_i),
        .mode     (mode_q),
        .open_vec (open_vec),
        .rcd_vec  (rcd_vec),
        .pre_vec  (pre_vec),
        .rrd_busy (rrd_busy),
        .wtr_busy (wtr_busy),
        .wra_busy (wra_busy),
        .rtw_busy (rtw_busy),
        .prev_dir (prev_dir),
        .rsn      (rsn)
    );

    // Device mode: enter and leave the low-power states on legal commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_NORM;
        end else if (legal) begin
            case (cmd)
                C_PDE:        mode_q <= M_PD;
                C_SRE:        mode_q <= M_SR;
                C_PDX, C_SRX: mode_q <= M_NORM;
                default:      mode_q <= mode_q;
            endcase
        end
    end

    // Register the verdict as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            rsn_q  <= V_NONE;
        end else begin
            viol_q <= !legal;
            rsn_q  <= rsn;
        end
    end

    assign viol_o   = viol_q;
    assign reason_o = rsn_q;

    // R12
    illegal_keeps_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> $stable(open_vec));

    // R12
    illegal_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> $stable(mode_q));

    // R11
    powerdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_PD && cmd != C_PDX) |=> (mode_q == M_PD));

endmodule

// File: tb/test_dram_cmd_guard.sv
// Directed bench for the command legality checker: one task per scenario.
// Timing set: tRCD=3 tRRD=2 tWR=3 tWTR=2 tRTW=4 tRP=3 WL=3 RL=5, BL4.
module test_dram_cmd_guard;
    import dcg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cmd;
    logic [2:0] bank;
    logic       bl8;
    logic       viol;
    logic [3:0] reason;
    int         n_vec = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_cmd_guard i_dram_cmd_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .bank_i   (bank),
        .t_rcd_i  (4'd3),
        .t_rrd_i  (4'd2),
        .t_wr_i   (4'd3),
        .t_wtr_i  (4'd2),
        .t_rtw_i  (4'd4),
        .t_rp_i   (4'd3),
        .wl_i     (4'd3),
        .rl_i     (4'd5),
        .bl8_i    (bl8),
        .viol_o   (viol),
        .reason_o (reason)
    );

    // Compare the registered verdict with the expected one.
    task automatic check(input logic ev, input rsn_e er, input string tag);
        n_vec++;
        if (viol !== ev || reason !== 4'(er)) begin
            n_bad++;
            $display("FAIL %s: viol=%0d reason=%0d, expected viol=%0d reason=%0d",
                     tag, viol, reason, ev, 4'(er));
        end
    endtask

    // Drive one command for one cycle, then check its verdict.
    task automatic send(input cmd_e c, input int b, input rsn_e er, input string tag);
        cmd  = c;
        bank = 3'(b);
        @(negedge clk);
        check(er != V_NONE, er, tag);
        cmd = C_NOP;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check(1'b0, V_NONE, "R1 reset outputs");
        send(C_RD,   0, V_CLOSED, "R1 read after reset");
        send(C_PRE,  0, V_NOOPEN, "R3 PRE with no bank open");
        send(C_PREA, 0, V_NOOPEN, "R3 PREA with no bank open");
    endtask

    task automatic t_idle_cmds();
        send(C_MRS,  0, V_NONE,    "R3 MRS from idle");
        send(C_EMRS, 0, V_NONE,    "R3 EMRS from idle");
        send(C_REF,  0, V_NONE,    "R3 REF from idle");
        send(C_PDX,  0, V_BADEXIT, "R11 exit while in normal mode");
        send(C_RSV,  0, V_BADCODE, "R13 reserved code");
        send(C_NOP,  0, V_NONE,    "R2 NOP legal");
    endtask

    task automatic t_activate();
        send(C_ACT, 0, V_NONE,    "R4 first ACT");
        send(C_ACT, 1, V_RRD,     "R4 ACT inside tRRD");
        send(C_ACT, 1, V_NONE,    "R4 ACT at tRRD");
        send(C_ACT, 0, V_ROWOPEN, "R4 ACT to open bank");
        send(C_WR,  1, V_RCD,     "R5 WR inside tRCD");
        send(C_WR,  1, V_NONE,    "R5 WR at tRCD");
    endtask

    task automatic t_write_read();
        send(C_WR,  0, V_WRGAP, "R6 back-to-back WR");
        send(C_WR,  0, V_NONE,  "R12 illegal WR leaves no gap");
        send(C_RD,  1, V_WTR,   "R7 RD right after WR");
        send(C_ACT, 2, V_NONE,  "R4 ACT during write");
        idle(3);
        send(C_RD,  1, V_WTR,   "R7 RD at last blocked cycle");
        send(C_RD,  1, V_NONE,  "R7 RD at window end");
        send(C_RD,  0, V_RDGAP, "R6 back-to-back RD");
        send(C_WR,  0, V_RTW,   "R9 WR inside tRTW");
        idle(1);
        send(C_WR,  0, V_NONE,  "R9 WR at tRTW");
    endtask

    task automatic t_autoprecharge();
        idle(8);
        send(C_WRA, 0, V_NONE,    "R8 WRA issued");
        idle(5);
        send(C_RDA, 1, V_RDAWRA,  "R8 RDA during WRA action");
        send(C_RD,  1, V_NONE,    "R8 RD legal once tWTR met");
        send(C_RDA, 1, V_RDGAP,   "R6 RDA right after RD");
        send(C_RDA, 1, V_NONE,    "R8 RDA after WRA action");
        send(C_ACT, 0, V_BANKPRE, "R10 ACT before WRA precharge ends");
        send(C_ACT, 0, V_NONE,    "R10 ACT when WRA precharge ends");
        send(C_WR,  1, V_CLOSED,  "R10 RDA closed its bank");
        send(C_ACT, 1, V_BANKPRE, "R10 ACT during RDA precharge");
        idle(5);
        send(C_ACT, 1, V_NONE,    "R10 ACT when RDA precharge ends");
    endtask

    task automatic t_low_power();
        idle(4);
        send(C_PDE,  0, V_NOTIDLE, "R3 PDE with banks open");
        send(C_PREA, 0, V_NONE,    "R10 PREA closes all");
        send(C_PDE,  0, V_NOTIDLE, "R3 PDE during tRP");
        idle(1);
        send(C_PDE,  0, V_NONE,    "R3 PDE after tRP");
        send(C_ACT,  0, V_LOWPWR,  "R11 ACT in power-down");
        send(C_SRX,  0, V_LOWPWR,  "R11 wrong exit in power-down");
        send(C_PDX,  0, V_NONE,    "R11 power-down exit");
        send(C_RD,   0, V_CLOSED,  "R12 rejected ACT opened nothing");
        send(C_SRE,  0, V_NONE,    "R11 self-refresh entry");
        send(C_PDX,  0, V_LOWPWR,  "R11 wrong exit in self-refresh");
        send(C_MRS,  0, V_LOWPWR,  "R11 MRS in self-refresh");
        send(C_SRX,  0, V_NONE,    "R11 self-refresh exit");
        send(C_MRS,  0, V_NONE,    "R11 back in normal mode");
    endtask

    task automatic t_burst8();
        bl8 = 1'b1;
        send(C_ACT, 3, V_NONE, "R5 ACT for BL8 test");
        idle(2);
        send(C_WR,  3, V_NONE, "R7 WR with BL8");
        idle(7);
        send(C_RD,  3, V_WTR,  "R7 BL8 RD at last blocked cycle");
        send(C_RD,  3, V_NONE, "R7 BL8 RD at window end");
        bl8 = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cmd   = C_NOP;
        bank  = '0;
        bl8   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_cmds();
        t_activate();
        t_write_read();
        t_autoprecharge();
        t_low_power();
        t_burst8();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule